// File: doc/BRIEF.md
# Fixed-Width Pulse Repeater with Rate Limiting

This block repeats pulses on several independent channels. Each channel takes an asynchronous input and detects its leading edge. For every edge it accepts, it emits exactly one output pulse of a fixed length, whatever the width of the input pulse. After a pulse starts, the channel ignores further edges until a spacing window has run out. This holds the output duty cycle at or below 1/200, which protects the output drivers downstream.

One global select sets the sense of both inputs and outputs, active-high or active-low. In active-low mode the idle level is high, so any drop of an input from high to low is taken as a trigger. An optional glitch filter can sit between the synchronizer and the edge detector. When enabled, a level change must stay stable for a set number of cycles before it is seen.

The default parameters assume a 125 MHz clock:
- The output pulse lasts 150 cycles (1.2 us).
- The spacing window is 30000 cycles (240 us).
- The filter needs 4 stable cycles.

Top module: `pulse_repeater`

## Requirements
- R1: Every accepted trigger drives the channel output to its active level for exactly PULSE_CYCLES (150) consecutive cycles, whatever the width of the input pulse.
- R2: Only the leading (idle-to-active) transition of an input triggers. Holding the input active, or returning it to idle, starts no pulse.
- R3: Two accepted pulses on one channel start at least WINDOW_CYCLES (30000) cycles apart. Take an input edge driven c cycles after the edge that was accepted. It is discarded for c = WINDOW_CYCLES-1 and accepted for c = WINDOW_CYCLES.
- R4: When `active_low` = 0, inputs idle low, a rising edge triggers, and outputs idle low with high pulses. When `active_low` = 1, inputs idle high, a falling edge triggers, and outputs idle high with low pulses.
- R5: In active-low mode, an input that falls from high and stays low (for example, because its source has lost power) produces exactly one pulse.
- R6: With `filt_en` = 1, a new input level must be sampled on FILTER_CYCLES (4) consecutive cycles before it counts. A 3-cycle excursion is ignored with no pulse and no reject. A 4-cycle one is accepted, and the output goes active 7 clock edges after the edge that first samples the input.
- R7: The channels are independent. With the filter off, an accepted input makes the output active on the 4th clock edge after the edge that first samples the input. This is within 10 cycles (80 ns).
- R8: An edge discarded inside the window raises `reject[c]` for exactly one cycle, in the cycle where an accepted pulse would have started. An accepted edge raises no reject.
- R9: While `rst` is held, every output sits at the idle level for the selected polarity and no reject is raised. Reset clears the spacing windows, so the first edge after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 125 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| active_low | input | 1 | Polarity select: 0 active-high, 1 active-low |
| filt_en | input | 1 | Enables the glitch filter on all channels |
| trig_in | input | NUM_CH | Asynchronous trigger inputs, one bit per channel |
| pulse_out | output | NUM_CH | Registered fixed-width pulse outputs |
| reject | output | NUM_CH | One-cycle strobes for edges discarded by the window |

## Verification
The assertions assume that `active_low` and `filt_en` change only while `rst` is held. A live polarity flip would look like an edge on every channel at once. The stimulus therefore sets both selects during reset and changes them only there. It holds every input level for at least one whole clock, driven at the falling clock edge, so that each intended edge is sampled and none is lost. Inputs return to idle before they are driven active again, so each drive produces exactly one leading edge.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } pol_e;

  typedef struct packed {
    logic pulse;
    logic reject;
  } chan_res_t;

  function automatic int cnt_width(input int max_val);
    return (max_val > 1) ? $clog2(max_val) : 1;
  endfunction
endpackage

// File: rtl/pr_sync.sv
module pr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic idle_lvl,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{idle_lvl}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pr_filter.sv
module pr_filter
  import pr_pkg::*;
#(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  localparam int CW = cnt_width(STABLE);
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [CW-1:0] cnt;
  logic          lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      lvl <= d;
    end else if (d != lvl) begin
      if (cnt == LAST) begin
        cnt <= '0;
        lvl <= d;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  assign q = lvl;
endmodule

// File: rtl/pr_chan.sv
module pr_chan
  import pr_pkg::*;
#(
  parameter int PULSE_CYCLES  = 150,
  parameter int WINDOW_CYCLES = 30000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pol,
  input  logic      lvl,
  output chan_res_t res
);
  localparam int WW = cnt_width(WINDOW_CYCLES);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYCLES - 1);
  localparam logic [WW-1:0] PW       = WW'(PULSE_CYCLES);

  logic          prev;
  logic [WW-1:0] win;
  logic          lead, busy, accept, drive;
  logic          out_q, rej_q;

  assign lead   = lvl & ~prev;
  assign busy   = (win != '0);
  assign accept = lead & ~busy;
  assign drive  = accept | (busy & (win < PW));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      win   <= '0;
      out_q <= pol;
      rej_q <= 1'b0;
    end else begin
      prev  <= lvl;
      out_q <= drive ^ pol;
      rej_q <= lead & busy;
      if (accept)               win <= WW'(1);
      else if (win == WIN_LAST) win <= '0;
      else if (busy)            win <= win + 1'b1;
    end
  end

  assign res.pulse  = out_q;
  assign res.reject = rej_q;
endmodule

// File: rtl/pulse_repeater.sv
module pulse_repeater
  import pr_pkg::*;
#(
  parameter int NUM_CH        = 6,
  parameter int SYNC_STAGES   = 2,
  parameter int FILTER_CYCLES = 4,
  parameter int PULSE_CYCLES  = 150,
  parameter int WINDOW_CYCLES = 30000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_low,
  input  logic              filt_en,
  input  logic [NUM_CH-1:0] trig_in,
  output logic [NUM_CH-1:0] pulse_out,
  output logic [NUM_CH-1:0] reject
);
  pol_e pol;
  assign pol = pol_e'(active_low);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic      raw, norm, clean;
    chan_res_t res;

    pr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .idle_lvl(pol == POL_LOW), .d(trig_in[c]), .q(raw)
    );

    assign norm = raw ^ (pol == POL_LOW);

    pr_filter #(.STABLE(FILTER_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .en(filt_en), .d(norm), .q(clean)
    );

    pr_chan #(.PULSE_CYCLES(PULSE_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES)) u_chan (
      .clk(clk), .rst(rst), .pol(pol == POL_LOW), .lvl(clean), .res(res)
    );

    assign pulse_out[c] = res.pulse;
    assign reject[c]    = res.reject;
  end
endmodule

// File: rtl/pr_checker.sv
module pr_checker #(
  parameter int NUM_CH        = 6,
  parameter int PULSE_CYCLES  = 150,
  parameter int WINDOW_CYCLES = 30000
) (
  input logic              clk,
  input logic              rst,
  input logic              active_low,
  input logic [NUM_CH-1:0] pulse_out,
  input logic [NUM_CH-1:0] reject
);
  localparam int PW_W  = $clog2(PULSE_CYCLES + 1);
  localparam int GAP_W = $clog2(WINDOW_CYCLES + 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic             act, act_d;
    logic [PW_W-1:0]  wcnt;
    logic [GAP_W-1:0] gap;

    assign act = pulse_out[c] ^ active_low;

    always_ff @(posedge clk) begin
      if (rst) begin
        act_d <= 1'b0;
        wcnt  <= '0;
        gap   <= GAP_W'(WINDOW_CYCLES);
      end else begin
        act_d <= act;
        if (act) wcnt <= (wcnt == PW_W'(PULSE_CYCLES)) ? wcnt : wcnt + 1'b1;
        else     wcnt <= '0;
        if (act && !act_d)                     gap <= GAP_W'(1);
        else if (gap < GAP_W'(WINDOW_CYCLES))  gap <= gap + 1'b1;
      end
    end

    AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
      act |-> (wcnt < PW_W'(PULSE_CYCLES))); // R1
    AST_PULSE_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
      (!act && act_d) |-> (wcnt == PW_W'(PULSE_CYCLES))); // R1
    AST_START_SPACING: assert property (@(posedge clk) disable iff (rst)
      (act && !act_d) |-> (gap >= GAP_W'(WINDOW_CYCLES))); // R3
    AST_REJECT_SINGLE: assert property (@(posedge clk) disable iff (rst)
      reject[c] |=> !reject[c]); // R8
    AST_REJECT_NOT_START: assert property (@(posedge clk) disable iff (rst)
      reject[c] |-> !(act && !act_d)); // R8
    AST_IDLE_IN_RESET: assert property (@(posedge clk)
      (rst && $past(rst)) |-> (!act && !reject[c])); // R9
  end
endmodule

bind pulse_repeater pr_checker #(
  .NUM_CH(NUM_CH), .PULSE_CYCLES(PULSE_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES)
) u_pr_checker (
  .clk(clk), .rst(rst), .active_low(active_low),
  .pulse_out(pulse_out), .reject(reject)
);

// File: tb/pulse_repeater_bench.sv
`timescale 1ns/1ps
module pulse_repeater_bench;
  localparam int NCH = 6;
  localparam int PW  = 150;
  localparam int WIN = 30000;
  localparam int LAT = 4;
  localparam int LATF = 7;

  typedef struct { int ch; longint start; } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic active_low = 1'b0;
  logic filt_en = 1'b0;
  logic [NCH-1:0] trig_in = '0;
  logic [NCH-1:0] pulse_out, reject;

  longint cyc = 0;
  int nchk = 0, nfail = 0;
  exp_t sb[$];
  int rej_cnt[NCH];
  int pls_cnt[NCH];
  int wid[NCH];
  logic [NCH-1:0] prev_a = '0;

  pulse_repeater u_pulse_repeater (
    .clk(clk), .rst(rst), .active_low(active_low), .filt_en(filt_en),
    .trig_in(trig_in), .pulse_out(pulse_out), .reject(reject)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: pops expected starts, measures widths, counts rejects
  initial begin
    for (int c = 0; c < NCH; c++) begin rej_cnt[c] = 0; pls_cnt[c] = 0; wid[c] = 0; end
    forever begin
      @(negedge clk);
      if (rst) begin
        prev_a = '0;
        for (int c = 0; c < NCH; c++) wid[c] = 0;
      end else begin
        for (int c = 0; c < NCH; c++) begin
          logic a;
          a = pulse_out[c] ^ active_low;
          if (reject[c]) rej_cnt[c]++;
          if (a && !prev_a[c]) begin
            int idx;
            idx = -1;
            pls_cnt[c]++;
            wid[c] = 1;
            for (int i = 0; i < sb.size(); i++)
              if (idx < 0 && sb[i].ch == c) idx = i;
            if (idx < 0) begin
              check(1'b0, "R3 unexpected pulse", c, -1);
            end else begin
              check(sb[idx].start == cyc, "R7 start cycle", cyc, sb[idx].start);
              sb.delete(idx);
            end
          end else if (a) begin
            wid[c]++;
          end else if (prev_a[c]) begin
            check(wid[c] == PW, "R1 pulse width", wid[c], PW);
          end
          prev_a[c] = a;
        end
      end
    end
  end

  task automatic wait_to(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic go_active(input logic [NCH-1:0] m, input logic [NCH-1:0] acc, input int lat);
    for (int c = 0; c < NCH; c++) if (acc[c]) sb.push_back('{c, cyc + lat});
    for (int c = 0; c < NCH; c++) if (m[c]) trig_in[c] = ~active_low;
  endtask

  task automatic go_idle(input logic [NCH-1:0] m);
    for (int c = 0; c < NCH; c++) if (m[c]) trig_in[c] = active_low;
  endtask

  task automatic pulse(input logic [NCH-1:0] m, input logic [NCH-1:0] acc, input int hold, input int lat);
    go_active(m, acc, lat);
    repeat (hold) @(negedge clk);
    go_idle(m);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 190000);
    finish_run();
  end

  initial begin
    longint n0;
    int r0, r1, r2, r3, p0;
    // reset, active-high
    repeat (5) @(negedge clk);
    check(pulse_out == '0, "R9 idle high-mode", pulse_out, 0);
    check(reject == '0, "R9 no reject", reject, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R7: short pulses on 0 and 2, long hold on 1
    n0 = cyc;
    go_active(6'b000111, 6'b000111, LAT);
    @(negedge clk);
    go_idle(6'b000101);
    repeat (499) @(negedge clk);
    go_idle(6'b000010);

    // R8: edge inside the window on channel 1
    wait_to(n0 + 1000);
    r1 = rej_cnt[1];
    pulse(6'b000010, '0, 1, LAT);
    repeat (10) @(negedge clk);
    check(rej_cnt[1] == r1 + 1, "R8 reject strobe", rej_cnt[1], r1 + 1);
    check(pls_cnt[1] == 1, "R2 long hold single pulse", pls_cnt[1], 1);

    // R3 boundaries
    r0 = rej_cnt[0]; r2 = rej_cnt[2];
    wait_to(n0 + WIN - 1);
    pulse(6'b000001, '0, 1, LAT);
    wait_to(n0 + WIN);
    pulse(6'b000100, 6'b000100, 1, LAT);
    repeat (20) @(negedge clk);
    check(rej_cnt[0] == r0 + 1, "R3 rejected at WIN-1", rej_cnt[0], r0 + 1);
    check(rej_cnt[2] == r2, "R8 no reject on accept", rej_cnt[2], r2);

    // R7: all channels at once, channel 2 still in window
    wait_to(n0 + WIN + 300);
    r2 = rej_cnt[2];
    pulse(6'b111111, 6'b111011, 2, LAT);
    repeat (200) @(negedge clk);
    check(rej_cnt[2] == r2 + 1, "R7 channel 2 independent reject", rej_cnt[2], r2 + 1);
    check(sb.size() == 0, "R7 all pulses seen", sb.size(), 0);

    // R4 R5: active-low mode
    rst = 1'b1; active_low = 1'b1; trig_in = '1;
    repeat (3) @(negedge clk);
    check(pulse_out == '1, "R9 idle low-mode", pulse_out, 6'h3f);
    rst = 1'b0;
    @(negedge clk);
    p0 = pls_cnt[0];
    pulse(6'b000001, 6'b000001, 2000, LAT);
    repeat (200) @(negedge clk);
    check(pls_cnt[0] == p0 + 1, "R5 sustained drop one pulse", pls_cnt[0], p0 + 1);
    check(sb.size() == 0, "R4 low pulse seen", sb.size(), 0);

    // R9: reset clears an open window
    pulse(6'b001000, 6'b001000, 1, LAT);
    repeat (300) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    r3 = rej_cnt[3];
    pulse(6'b001000, 6'b001000, 1, LAT);
    repeat (200) @(negedge clk);
    check(rej_cnt[3] == r3, "R9 window cleared", rej_cnt[3], r3);
    check(sb.size() == 0, "R9 accepted after reset", sb.size(), 0);

    // R6: glitch filter
    rst = 1'b1; active_low = 1'b0; filt_en = 1'b1; trig_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    r3 = rej_cnt[3]; p0 = pls_cnt[3];
    pulse(6'b001000, '0, 3, LATF);
    repeat (50) @(negedge clk);
    check(pls_cnt[3] == p0, "R6 glitch suppressed", pls_cnt[3], p0);
    check(rej_cnt[3] == r3, "R6 glitch no reject", rej_cnt[3], r3);
    pulse(6'b010000, 6'b010000, 4, LATF);
    repeat (200) @(negedge clk);
    check(sb.size() == 0, "R6 filtered pulse seen", sb.size(), 0);

    finish_run();
  end
endmodule